// File: doc/BRIEF.md
# Two-Thread Instruction Issue Scheduler

This block sits between instruction decode and the execution pipelines of a core that runs two hardware thread contexts on shared integer, memory and floating-point pipelines. Each cycle it picks at most one instruction to issue. Decode pushes instructions into a small queue per thread. The scheduler looks at the head of each queue and rotates priority between the threads that are able to go.

A thread is held back for any of these reasons:
- one of the registers its head instruction reads or writes still has a result outstanding;
- issuing now would land the result on the single writeback port in a cycle that is already claimed;
- it is waiting on a data cache miss;
- its store queue is full.

Each thread has its own set of pending bits, one per register. A bit is set when an instruction that writes that register issues, and cleared when writeback reports the register. A gather/scatter memory instruction stays at the head of its queue and issues once per vector lane, tagged with a rising subcycle number. A rollback request for a thread empties that thread's queue, clears its pending bits and abandons any gather that is part-way through.

Each thread has a lane state machine with two states:
- `LS_SINGLE`: the head is treated as one instruction.
- `LS_LANES`: a gather is part-way through its lanes.

It has three transitions:
- *start-gather* goes from `LS_SINGLE` to `LS_LANES` when lane 0 of a gather issues.
- *last-lane* goes from `LS_LANES` to `LS_SINGLE` when lane NLANE-1 issues and the queue entry is popped.
- *abort* goes from any state to `LS_SINGLE` on a rollback for that thread.

Top module: `mtis_issue_sched`

## Requirements
- R1: After reset `iss_valid` is low and every bit of `enq_ready` is high. No register is pending, and every thread is in `LS_SINGLE`.
- R2: If the head of a thread queue is eligible in cycle c, `iss_valid` is high in cycle c+1. The issue output carries the thread id, the destination, the pipe code and the subcycle, which is 0 for a non-gather instruction. At most one instruction issues per cycle.
- R3: Each thread queue holds QDEPTH entries and issues them in arrival order. `enq_ready[t]` is low while queue t is full, and an enqueue offered while it is full is dropped.
- R4: When both threads are eligible in consecutive cycles, the issuing thread id alternates from one cycle to the next.
- R5: An instruction does not issue while the pending bit of either of its source registers is set in its own thread. The other thread is not affected.
- R6: An instruction does not issue while the pending bit of its destination register is set in its own thread.
- R7: The destination pending bit is set when an instruction issues. It is cleared by `wb_valid` together with `wb_tid` and `wb_reg`. After that, a waiting dependent instruction issues within 2 cycles.
- R8: A thread whose `miss_wait` or `stq_full` bit is high in cycle c does not issue from a decision made in cycle c. The other thread keeps issuing.
- R9: The pipe code sets the latency: 0 is integer (LAT_INT), 1 is memory (LAT_MEM), 2 is floating point (LAT_FP), and 3 uses LAT_INT. No two issues decided in cycles c1 and c2 satisfy c1 + L1 = c2 + L2. An instruction held back for this reason issues in a later cycle.
- R10: An instruction with the gather flag set and pipe code 1 issues NLANE times from one queue entry, with subcycles 0 up to NLANE-1 in ascending order. Its own pending bit does not stop lanes 1 onward. With any other pipe code the gather flag has no effect and the instruction issues once with subcycle 0.
- R11: A rollback of thread t empties t's queue, clears all of t's pending bits and returns t to `LS_SINGLE`. It blocks t from issuing in that cycle, and an enqueue to t in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | NTHR | Per-thread enqueue strobe from decode |
| enq_ready | output | NTHR | Per-thread queue not full |
| enq_dst | input | NTHR*RW | Destination register per thread |
| enq_src_a | input | NTHR*RW | First source register per thread |
| enq_src_b | input | NTHR*RW | Second source register per thread |
| enq_pipe | input | NTHR*2 | Pipe code per thread (0 int, 1 mem, 2 fp) |
| enq_gather | input | NTHR | Gather/scatter flag per thread |
| miss_wait | input | NTHR | Thread waits on a data cache miss |
| stq_full | input | NTHR | Thread's store queue is full |
| wb_valid | input | 1 | Writeback report strobe |
| wb_tid | input | TW | Thread of the reported register |
| wb_reg | input | RW | Register updated by writeback |
| rb_valid | input | 1 | Rollback request |
| rb_tid | input | TW | Thread to roll back |
| iss_valid | output | 1 | Instruction issued |
| iss_tid | output | TW | Issuing thread |
| iss_dst | output | RW | Destination of the issued instruction |
| iss_pipe | output | 2 | Pipe code of the issued instruction |
| iss_sub | output | SW | Lane subcycle of the issued instruction |

## Verification
Corruption in the scheduler shows up at the issue port within a cycle or two.

- A pending bit stuck high leaves a dependent instruction queued forever after its writeback report.
- A pending bit lost early lets that instruction out ahead of the report.
- A wrong writeback slot shows as two issues whose decision cycle plus latency meet, which can be seen the cycle the second one issues.
- A lane counter or lane state that is off breaks the ascending subcycle sequence on the very next lane.
- A rollback that leaves stale state lets a squashed instruction issue, or keeps a fresh one waiting.

// File: rtl/mtis_pkg.sv
package mtis_pkg;

    typedef enum logic [1:0] {
        PIPE_INT = 2'd0,
        PIPE_MEM = 2'd1,
        PIPE_FP  = 2'd2,
        PIPE_RSV = 2'd3
    } pipe_e;

    typedef enum logic {
        LS_SINGLE = 1'b0,
        LS_LANES  = 1'b1
    } lane_state_e;

endpackage

// File: rtl/mtis_queue.sv
module mtis_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 15,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [AW:0]   cnt_q;
    logic          push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem_q[rd_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mtis_scoreboard.sv
module mtis_scoreboard #(
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            set_en,
    input  logic [RW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);
    logic [NREG-1:0] pend_d;

    always_comb begin
        pend_d = pend;
        if (clr_en) pend_d[clr_idx] = 1'b0;
        if (set_en) pend_d[set_idx] = 1'b1;
        if (flush)  pend_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end
endmodule

// File: rtl/mtis_wb_slots.sv
module mtis_wb_slots #(
    parameter int MAXL = 8,
    localparam int LW  = $clog2(MAXL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_en,
    input  logic [LW-1:0] claim_lat,
    output logic [MAXL:0] busy
);
    logic [MAXL:0] busy_d;

    for (genvar k = 0; k <= MAXL; k++) begin : g_slot
        if (k < MAXL) begin : g_shift
            assign busy_d[k] = busy[k+1] | (claim_en && claim_lat == LW'(k + 1));
        end else begin : g_top
            assign busy_d[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= '0;
        else        busy <= busy_d;
    end
endmodule

// File: rtl/mtis_lane_fsm.sv
module mtis_lane_fsm
    import mtis_pkg::*;
#(
    parameter int NLANE = 16,
    localparam int SW   = $clog2(NLANE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          fire,
    input  logic          gather,
    output logic [SW-1:0] sub,
    output logic          pop,
    output logic          in_lanes
);
    localparam logic [SW-1:0] LAST = SW'(NLANE - 1);

    lane_state_e   st_q, st_d;
    logic [SW-1:0] sub_q, sub_d;

    always_comb begin
        st_d  = st_q;
        sub_d = sub_q;
        if (abort) begin
            st_d  = LS_SINGLE;
            sub_d = '0;
        end else if (fire) begin
            unique case (st_q)
                LS_SINGLE: begin
                    if (gather) begin
                        st_d  = LS_LANES;
                        sub_d = SW'(1);
                    end
                end
                LS_LANES: begin
                    if (sub_q == LAST) begin
                        st_d  = LS_SINGLE;
                        sub_d = '0;
                    end else begin
                        sub_d = sub_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LS_SINGLE;
            sub_q <= '0;
        end else begin
            st_q  <= st_d;
            sub_q <= sub_d;
        end
    end

    always_comb begin
        unique case (st_q)
            LS_SINGLE: begin
                sub      = '0;
                in_lanes = 1'b0;
                pop      = fire && !gather;
            end
            LS_LANES: begin
                sub      = sub_q;
                in_lanes = 1'b1;
                pop      = fire && (sub_q == LAST);
            end
        endcase
    end
endmodule

// File: rtl/mtis_issue_sched.sv
module mtis_issue_sched
    import mtis_pkg::*;
#(
    parameter int NTHR    = 2,
    parameter int NREG    = 16,
    parameter int QDEPTH  = 4,
    parameter int NLANE   = 16,
    parameter int LAT_INT = 1,
    parameter int LAT_MEM = 4,
    parameter int LAT_FP  = 8,
    localparam int TW     = $clog2(NTHR),
    localparam int RW     = $clog2(NREG),
    localparam int SW     = $clog2(NLANE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTHR-1:0]    enq_valid,
    output logic [NTHR-1:0]    enq_ready,
    input  logic [NTHR*RW-1:0] enq_dst,
    input  logic [NTHR*RW-1:0] enq_src_a,
    input  logic [NTHR*RW-1:0] enq_src_b,
    input  logic [NTHR*2-1:0]  enq_pipe,
    input  logic [NTHR-1:0]    enq_gather,
    input  logic [NTHR-1:0]    miss_wait,
    input  logic [NTHR-1:0]    stq_full,
    input  logic               wb_valid,
    input  logic [TW-1:0]      wb_tid,
    input  logic [RW-1:0]      wb_reg,
    input  logic               rb_valid,
    input  logic [TW-1:0]      rb_tid,
    output logic               iss_valid,
    output logic [TW-1:0]      iss_tid,
    output logic [RW-1:0]      iss_dst,
    output logic [1:0]         iss_pipe,
    output logic [SW-1:0]      iss_sub
);
    localparam int MAXA = (LAT_INT > LAT_MEM) ? LAT_INT : LAT_MEM;
    localparam int MAXL = (MAXA > LAT_FP) ? MAXA : LAT_FP;
    localparam int LW   = $clog2(MAXL + 1);
    localparam int IW   = 3 * RW + 3;

    function automatic logic [LW-1:0] lat_of(input logic [1:0] p);
        case (pipe_e'(p))
            PIPE_MEM: return LW'(LAT_MEM);
            PIPE_FP:  return LW'(LAT_FP);
            default:  return LW'(LAT_INT);
        endcase
    endfunction

    logic [IW-1:0]   head   [NTHR];
    logic [RW-1:0]   h_dst  [NTHR];
    logic [RW-1:0]   h_sa   [NTHR];
    logic [RW-1:0]   h_sb   [NTHR];
    logic [1:0]      h_pipe [NTHR];
    logic [SW-1:0]   h_sub  [NTHR];
    logic [LW-1:0]   h_lat  [NTHR];
    logic [NREG-1:0] pend   [NTHR];
    logic [NTHR-1:0] q_empty, q_full, q_pop, rb_hit, elig, fire, in_lanes, h_gath, hazard;
    logic [MAXL:0]   wb_busy;
    logic [TW-1:0]   rr_last, win;
    logic            win_valid;

    assign enq_ready = ~q_full;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [IW-1:0] din;
        assign din = {enq_gather[t], enq_pipe[2*t +: 2], enq_src_b[t*RW +: RW],
                      enq_src_a[t*RW +: RW], enq_dst[t*RW +: RW]};
        assign rb_hit[t] = rb_valid && (rb_tid == TW'(t));

        mtis_queue #(.DEPTH(QDEPTH), .W(IW)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (rb_hit[t]),
            .push  (enq_valid[t]),
            .din   (din),
            .pop   (q_pop[t]),
            .dout  (head[t]),
            .empty (q_empty[t]),
            .full  (q_full[t])
        );

        assign h_dst[t]  = head[t][RW-1:0];
        assign h_sa[t]   = head[t][2*RW-1:RW];
        assign h_sb[t]   = head[t][3*RW-1:2*RW];
        assign h_pipe[t] = head[t][3*RW+1:3*RW];
        assign h_gath[t] = head[t][3*RW+2] && (h_pipe[t] == PIPE_MEM);
        assign h_lat[t]  = lat_of(h_pipe[t]);

        mtis_scoreboard #(.NREG(NREG)) u_score (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (rb_hit[t]),
            .set_en  (fire[t] && !in_lanes[t]),
            .set_idx (h_dst[t]),
            .clr_en  (wb_valid && (wb_tid == TW'(t))),
            .clr_idx (wb_reg),
            .pend    (pend[t])
        );

        mtis_lane_fsm #(.NLANE(NLANE)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .abort    (rb_hit[t]),
            .fire     (fire[t]),
            .gather   (h_gath[t]),
            .sub      (h_sub[t]),
            .pop      (q_pop[t]),
            .in_lanes (in_lanes[t])
        );

        assign hazard[t] = pend[t][h_sa[t]] | pend[t][h_sb[t]] | pend[t][h_dst[t]];
        assign elig[t]   = !q_empty[t] && !rb_hit[t] && !miss_wait[t] && !stq_full[t]
                           && !wb_busy[h_lat[t]] && (in_lanes[t] || !hazard[t]);
        assign fire[t]   = win_valid && (win == TW'(t));
    end

    // Rotating-priority pick, starting after the last thread that issued.
    always_comb begin
        win_valid = 1'b0;
        win       = '0;
        for (int k = 1; k <= NTHR; k++) begin
            int idx;
            idx = (int'(rr_last) + k) % NTHR;
            if (!win_valid && elig[idx]) begin
                win_valid = 1'b1;
                win       = TW'(idx);
            end
        end
    end

    mtis_wb_slots #(.MAXL(MAXL)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (win_valid),
        .claim_lat (h_lat[win]),
        .busy      (wb_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_last   <= TW'(NTHR - 1);
            iss_valid <= 1'b0;
            iss_tid   <= '0;
            iss_dst   <= '0;
            iss_pipe  <= '0;
            iss_sub   <= '0;
        end else begin
            iss_valid <= win_valid;
            if (win_valid) begin
                rr_last  <= win;
                iss_tid  <= win;
                iss_dst  <= h_dst[win];
                iss_pipe <= h_pipe[win];
                iss_sub  <= h_sub[win];
            end
        end
    end
endmodule

// File: rtl/mtis_sched_chk.sv
module mtis_sched_chk
    import mtis_pkg::*;
#(
    parameter int NTHR    = 2,
    parameter int NLANE   = 16,
    parameter int LAT_INT = 1,
    parameter int LAT_MEM = 4,
    parameter int LAT_FP  = 8,
    localparam int TW     = $clog2(NTHR),
    localparam int SW     = $clog2(NLANE)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NTHR-1:0] miss_wait,
    input logic [NTHR-1:0] stq_full,
    input logic            rb_valid,
    input logic [TW-1:0]   rb_tid,
    input logic            iss_valid,
    input logic [TW-1:0]   iss_tid,
    input logic [1:0]      iss_pipe,
    input logic [SW-1:0]   iss_sub
);
    localparam int MAXA = (LAT_INT > LAT_MEM) ? LAT_INT : LAT_MEM;
    localparam int MAXL = (MAXA > LAT_FP) ? MAXA : LAT_FP;

    logic [NTHR-1:0] prev_block;
    logic            prev_rb;
    logic [TW-1:0]   prev_rb_tid;
    logic [SW-1:0]   last_sub [NTHR];
    logic [MAXL:0]   occ;
    int              cur_lat;

    always_comb begin
        case (pipe_e'(iss_pipe))
            PIPE_MEM: cur_lat = LAT_MEM;
            PIPE_FP:  cur_lat = LAT_FP;
            default:  cur_lat = LAT_INT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_block  <= '0;
            prev_rb     <= 1'b0;
            prev_rb_tid <= '0;
            occ         <= '0;
            for (int t = 0; t < NTHR; t++) last_sub[t] <= '0;
        end else begin
            prev_block  <= miss_wait | stq_full;
            prev_rb     <= rb_valid;
            prev_rb_tid <= rb_tid;
            for (int k = 0; k <= MAXL; k++)
                occ[k] <= ((k < MAXL) ? occ[(k < MAXL) ? k + 1 : k] : 1'b0)
                          | (iss_valid && cur_lat == k + 1);
            if (iss_valid) last_sub[iss_tid] <= iss_sub;
        end
    end

    p_no_stall_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !prev_block[iss_tid]);

    p_no_rollback_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && prev_rb) |-> (iss_tid != prev_rb_tid));

    p_wb_slot_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !occ[cur_lat]);

    p_sub_mem_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sub != '0) |-> (iss_pipe == PIPE_MEM));

    p_sub_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_sub != '0) |-> (last_sub[iss_tid] == iss_sub - 1'b1));
endmodule

bind mtis_issue_sched mtis_sched_chk #(
    .NTHR(NTHR), .NLANE(NLANE), .LAT_INT(LAT_INT), .LAT_MEM(LAT_MEM), .LAT_FP(LAT_FP)
) u_sched_chk (
    .clk(clk), .rst_n(rst_n), .miss_wait(miss_wait), .stq_full(stq_full),
    .rb_valid(rb_valid), .rb_tid(rb_tid), .iss_valid(iss_valid), .iss_tid(iss_tid),
    .iss_pipe(iss_pipe), .iss_sub(iss_sub)
);

// File: tb/test_mtis_issue_sched.sv
module test_mtis_issue_sched;
    localparam int NTHR = 2, RW = 4, SW = 4, TW = 1, NLANE = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NTHR-1:0]    enq_valid = '0, enq_ready, enq_gather = '0, miss_wait = '0, stq_full = '0;
    logic [NTHR*RW-1:0] enq_dst = '0, enq_src_a = '0, enq_src_b = '0;
    logic [NTHR*2-1:0]  enq_pipe = '0;
    logic               wb_valid = 1'b0, rb_valid = 1'b0, iss_valid;
    logic [TW-1:0]      wb_tid = '0, rb_tid = '0, iss_tid;
    logic [RW-1:0]      wb_reg = '0, iss_dst;
    logic [1:0]         iss_pipe;
    logic [SW-1:0]      iss_sub;

    int checks = 0, errors = 0, cyc = 0, log_n = 0;
    int log_tid [64], log_dst [64], log_pipe [64], log_sub [64], log_cyc [64];
    bit done = 1'b0;

    always #4 clk = ~clk;

    mtis_issue_sched i_mtis_issue_sched (.*);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && iss_valid && log_n < 64) begin
            log_tid[log_n]  <= int'(iss_tid);
            log_dst[log_n]  <= int'(iss_dst);
            log_pipe[log_n] <= int'(iss_pipe);
            log_sub[log_n]  <= int'(iss_sub);
            log_cyc[log_n]  <= cyc;
            log_n           <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_enq(input int t, input int dst, input int a, input int b, input int pipe, input bit g);
        enq_valid[t] = 1'b1;
        enq_dst[t*RW +: RW]   = RW'(dst);
        enq_src_a[t*RW +: RW] = RW'(a);
        enq_src_b[t*RW +: RW] = RW'(b);
        enq_pipe[2*t +: 2]    = 2'(pipe);
        enq_gather[t]         = g;
    endtask

    task automatic enq1(input int t, input int dst, input int a, input int b, input int pipe, input bit g);
        set_enq(t, dst, a, b, pipe, g);
        @(negedge clk);
        enq_valid[t] = 1'b0;
    endtask

    task automatic wb(input int t, input int r);
        wb_valid = 1'b1; wb_tid = TW'(t); wb_reg = RW'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic rollback(input int t);
        rb_valid = 1'b1; rb_tid = TW'(t);
        @(negedge clk);
        rb_valid = 1'b0;
    endtask

    task automatic clean();
        rollback(0);
        rollback(1);
        wait_n(10);
        log_n = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(iss_valid == 1'b0, "R1 iss_valid after reset", int'(iss_valid), 0);
        check(enq_ready == 2'b11, "R1 enq_ready after reset", int'(enq_ready), 3);
    endtask

    task automatic t_basic();
        clean();
        enq1(0, 3, 1, 2, 2, 1'b0);
        wait_n(2);
        check(log_n == 1, "R2 one issue", log_n, 1);
        check(log_tid[0] == 0 && log_dst[0] == 3, "R2 tid/dst", log_dst[0], 3);
        check(log_pipe[0] == 2 && log_sub[0] == 0, "R2 pipe/sub", log_pipe[0], 2);
    endtask

    task automatic t_raw();
        clean();
        enq1(0, 5, 1, 2, 0, 1'b0);
        enq1(0, 6, 5, 3, 0, 1'b0);
        enq1(1, 6, 5, 5, 0, 1'b0);
        wait_n(6);
        check(log_n == 2, "R5 only independent issues", log_n, 2);
        check(log_dst[0] == 5 && log_tid[1] == 1, "R5 other thread unaffected", log_tid[1], 1);
        wb(1, 6);
        wb(0, 5);
        wait_n(2);
        check(log_n == 3 && log_dst[2] == 6 && log_tid[2] == 0, "R7 issue after wb", log_n, 3);
    endtask

    task automatic t_waw();
        clean();
        enq1(0, 7, 1, 2, 2, 1'b0);
        enq1(0, 7, 3, 4, 0, 1'b0);
        wait_n(12);
        check(log_n == 1, "R6 WAW blocks", log_n, 1);
        wb(0, 7);
        wait_n(2);
        check(log_n == 2 && log_pipe[1] == 0, "R6 WAW released by wb", log_n, 2);
    endtask

    task automatic t_rr();
        clean();
        for (int i = 1; i <= 3; i++) begin
            set_enq(0, i, 8, 9, 0, 1'b0);
            set_enq(1, i, 8, 9, 0, 1'b0);
            @(negedge clk);
        end
        enq_valid = '0;
        wait_n(6);
        check(log_n == 6, "R4 all issued", log_n, 6);
        for (int i = 1; i < 6; i++)
            check(log_tid[i] != log_tid[i-1], "R4 alternation", log_tid[i], 1 - log_tid[i-1]);
        check(log_dst[0] == 1 && log_dst[2] == 2 && log_dst[4] == 3, "R3 fifo order", log_dst[4], 3);
    endtask

    task automatic t_stall();
        clean();
        miss_wait[0] = 1'b1;
        enq1(0, 1, 8, 9, 0, 1'b0);
        enq1(1, 1, 8, 9, 0, 1'b0);
        wait_n(5);
        check(log_n == 1 && log_tid[0] == 1, "R8 miss blocks only its thread", log_n, 1);
        miss_wait[0] = 1'b0;
        wait_n(3);
        check(log_n == 2 && log_tid[1] == 0, "R8 miss released", log_n, 2);
        stq_full[1] = 1'b1;
        enq1(1, 2, 8, 9, 0, 1'b0);
        wait_n(5);
        check(log_n == 2, "R8 store queue full blocks", log_n, 2);
        stq_full[1] = 1'b0;
        wait_n(3);
        check(log_n == 3 && log_tid[2] == 1, "R8 store queue released", log_n, 3);
    endtask

    task automatic t_full();
        clean();
        miss_wait[0] = 1'b1;
        for (int i = 1; i <= 4; i++) enq1(0, i, 8, 9, 0, 1'b0);
        check(enq_ready[0] == 1'b0, "R3 ready low when full", int'(enq_ready[0]), 0);
        enq1(0, 15, 8, 9, 0, 1'b0);
        miss_wait[0] = 1'b0;
        wait_n(8);
        check(log_n == 4, "R3 overflow dropped", log_n, 4);
        check(log_dst[0] == 1 && log_dst[3] == 4, "R3 order after full", log_dst[3], 4);
    endtask

    task automatic t_collide();
        clean();
        enq1(0, 1, 8, 9, 1, 1'b0);
        enq1(0, 2, 8, 9, 0, 1'b0);
        enq1(0, 3, 8, 9, 0, 1'b0);
        enq1(0, 4, 8, 9, 0, 1'b0);
        wait_n(6);
        check(log_n == 4, "R9 all issued", log_n, 4);
        check(log_cyc[1] - log_cyc[0] == 1, "R9 gap 1", log_cyc[1] - log_cyc[0], 1);
        check(log_cyc[2] - log_cyc[1] == 1, "R9 gap 2", log_cyc[2] - log_cyc[1], 1);
        check(log_cyc[3] - log_cyc[2] == 2, "R9 delayed by slot clash", log_cyc[3] - log_cyc[2], 2);
    endtask

    task automatic t_gather();
        clean();
        enq1(0, 9, 1, 2, 1, 1'b1);
        wait_n(20);
        check(log_n == NLANE, "R10 lane count", log_n, NLANE);
        for (int i = 0; i < NLANE; i++)
            check(log_sub[i] == i && log_tid[i] == 0 && log_cyc[i] == log_cyc[0] + i,
                  "R10 lane sequence", log_sub[i], i);
        clean();
        enq1(0, 3, 1, 2, 0, 1'b1);
        wait_n(4);
        check(log_n == 1 && log_sub[0] == 0, "R10 flag ignored off memory pipe", log_n, 1);
    endtask

    task automatic t_rollback();
        clean();
        enq1(0, 5, 1, 2, 0, 1'b0);
        enq1(0, 6, 5, 3, 0, 1'b0);
        wait_n(4);
        rollback(0);
        enq1(0, 7, 5, 5, 0, 1'b0);
        wait_n(4);
        check(log_n == 2 && log_dst[1] == 7, "R11 queue and pending cleared", log_dst[1], 7);
        enq1(1, 1, 8, 9, 0, 1'b0);
        set_enq(1, 2, 8, 9, 0, 1'b0);
        rollback(1);
        enq_valid = '0;
        wait_n(5);
        check(log_n == 2, "R11 no issue in rollback cycle, enqueue dropped", log_n, 2);
        clean();
        enq1(0, 9, 1, 2, 1, 1'b1);
        wait_n(3);
        rollback(0);
        wait_n(3);
        check(log_n > 0 && log_n < NLANE, "R11 gather abandoned", log_n, 3);
        log_n = 0;
        enq1(0, 9, 9, 9, 1, 1'b0);
        wait_n(3);
        check(log_n == 1 && log_sub[0] == 0, "R11 lane state reset", log_sub[0], 0);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_raw();
        t_waw();
        t_rr();
        t_stall();
        t_full();
        t_collide();
        t_gather();
        t_rollback();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule